// File: doc/BRIEF.md
# Serial Port Host Register Front End

This block is the host-facing register interface of a 16450/16550-style serial port. A host bus presents a 3-bit offset, a read or a write strobe and a byte of write data. The block combines these with the divisor-latch access bit (`dlab`) to select one of four registers. A read at offset 0 returns the received byte, and a write at offset 0 hands a byte to the transmit holding stage. Offset 1 holds the four interrupt enable bits. At offset 2 the direction selects the register: a write goes to the FIFO control logic and a read returns the interrupt identification byte.

The serial shifters, the FIFO storage and the interrupt priority encoder sit in the neighbouring datapath. This block gives them one-cycle pop and push strobes and FIFO enable, flush and trigger-level controls. The enable bits gate five raw event flags from that datapath. A single registered, active-high interrupt line comes out of that gating. Line and modem status keep updating in the datapath whether or not their interrupts are enabled.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, the interrupt enables are 0, FIFO mode is off, the trigger level is 00 and `irq` is 0.
- R2: With `dlab`=0 at offset 0, a read returns `rx_data` on `bus_rdata` and raises `rx_pop` in the same cycle. A write puts `bus_wdata` on `tx_data` and raises `tx_push` in the same cycle. With `dlab`=1 neither strobe is raised, and reads at offsets 0 and 1 return 0.
- R3: Read data is combinational, valid in the cycle of `bus_rd`. Reads at offsets 3 to 7 return 0, and writes there change no state.
- R4: With `dlab`=0, a write at offset 1 stores `bus_wdata[3:0]` as the enables. A read there returns {4'b0000, enables}. With `dlab`=1 the enables are left unchanged.
- R5: `irq` is registered: one cycle after the inputs it equals the OR of four gated terms. Enable bit 0 gates `ev_rx_avail`, and also gates `ev_rx_timeout` but only in FIFO mode. Bit 1 gates `ev_thr_empty`, bit 2 gates `ev_line_err` and bit 3 gates `ev_modem_chg`.
- R6: While all four enables are 0, `irq` stays 0. An identification read then returns bits 5:0 = 000001 ("nothing pending") in place of `iir_src`.
- R7: A read at offset 2, for either `dlab` value, returns {fifo_en, fifo_en, iir_src} when any enable bit is set.
- R8: A write at offset 2, for either `dlab` value, with bit 0 = 0 turns FIFO mode off from the next cycle. It also raises both `rx_fifo_clr` and `tx_fifo_clr` in the write cycle.
- R9: A write at offset 2 with bit 0 = 1 turns FIFO mode on. In the same cycle, bit 1 raises `rx_fifo_clr` and bit 2 raises `tx_fifo_clr`. Bits 7:6 become `fifo_trig` from the next cycle. When bit 0 = 0, bits 7:6 are ignored and `fifo_trig` holds its value.
- R10: FCR bit 3 (the DMA mode select) and bits 5:4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dlab | input | 1 | Divisor-latch access bit from the line control logic |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_data | input | 8 | Head byte of the receive buffer |
| rx_pop | output | 1 | Receive buffer was read |
| tx_data | output | 8 | Byte for the transmit holding stage |
| tx_push | output | 1 | Transmit buffer was written |
| ev_rx_avail | input | 1 | Raw received-data-available flag |
| ev_rx_timeout | input | 1 | Raw receive timeout flag |
| ev_thr_empty | input | 1 | Raw transmit-holding-empty flag |
| ev_line_err | input | 1 | Raw line status flag (overrun, parity, framing, break) |
| ev_modem_chg | input | 1 | Raw modem status change flag |
| iir_src | input | 6 | Identification code from the priority encoder |
| irq | output | 1 | Registered interrupt request, active high |
| fifo_en | output | 1 | FIFO mode |
| fifo_trig | output | 2 | Receive FIFO trigger level |
| rx_fifo_clr | output | 1 | Flush strobe for the receive FIFO |
| tx_fifo_clr | output | 1 | Flush strobe for the transmit FIFO |

## Verification
The strobes and the read data are combinational. The bench drives each access on a falling edge and checks them 1 ns later, within the same cycle. State changes (enables, FIFO mode, trigger level) take effect at the next rising edge. They are checked at the next falling edge, at the ports and by read-back. `irq` has one register stage, so the bench changes the event flags on a falling edge and samples `irq` one falling edge later, after exactly one rising edge.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;
  localparam int unsigned OFS_BUF = 0;
  localparam int unsigned OFS_IER = 1;
  localparam int unsigned OFS_FCR = 2;

  localparam int unsigned FCR_ON    = 0;
  localparam int unsigned FCR_RXCLR = 1;
  localparam int unsigned FCR_TXCLR = 2;
  localparam int unsigned FCR_TRIG  = 6;

  localparam int unsigned EV_N = 5;

  // ev bit order: {modem, line, thr, rx_timeout, rx_avail}
  function automatic logic gate_irq(input logic [3:0] en,
                                    input logic [EV_N-1:0] ev,
                                    input logic fen);
    logic rx_term;
    rx_term = ev[0] | (ev[1] & fen);
    return (en[0] & rx_term) | (en[1] & ev[2]) | (en[2] & ev[3]) | (en[3] & ev[4]);
  endfunction

  function automatic logic [7:0] iir_view(input logic fen,
                                          input logic any_en,
                                          input logic [5:0] src);
    logic [5:0] low;
    low = any_en ? src : 6'b000001;
    return {fen, fen, low};
  endfunction
endpackage

// File: rtl/uhr_decode.sv
module uhr_decode #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              dlab,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              buf_rd,
  output logic              buf_wr,
  output logic              ier_rd,
  output logic              ier_wr,
  output logic              iir_rd,
  output logic              fcr_wr
);
  timeunit 1ns; timeprecision 1ps;
  import uart_host_pkg::*;

  logic at_buf, at_ier, at_fcr;

  always_comb begin
    at_buf = (addr == ADDR_W'(OFS_BUF));
    at_ier = (addr == ADDR_W'(OFS_IER));
    at_fcr = (addr == ADDR_W'(OFS_FCR));
    buf_rd = rd & at_buf & ~dlab;
    buf_wr = wr & at_buf & ~dlab;
    ier_rd = rd & at_ier & ~dlab;
    ier_wr = wr & at_ier & ~dlab;
    iir_rd = rd & at_fcr;
    fcr_wr = wr & at_fcr;
  end
endmodule

// File: rtl/uhr_ier.sv
module uhr_ier #(
  parameter int unsigned IER_W = 4,
  parameter int unsigned EV_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [IER_W-1:0] wbits,
  input  logic [EV_W-1:0]  ev,
  input  logic             fen,
  output logic [IER_W-1:0] ier_q,
  output logic             irq_q,
  output logic             irq_next
);
  timeunit 1ns; timeprecision 1ps;
  import uart_host_pkg::*;

  always_comb irq_next = gate_irq(ier_q, ev, fen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= wbits;
      irq_q <= irq_next;
    end
  end
endmodule

// File: rtl/uhr_fcr.sv
module uhr_fcr #(
  parameter int unsigned TRIG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcr_wr,
  input  logic              w_on,
  input  logic              w_rxclr,
  input  logic              w_txclr,
  input  logic [TRIG_W-1:0] w_trig,
  output logic              fen_q,
  output logic [TRIG_W-1:0] trig_q,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              fcr_qual
);
  timeunit 1ns; timeprecision 1ps;

  logic fcr_off;

  always_comb begin
    fcr_qual = fcr_wr & w_on;
    fcr_off  = fcr_wr & ~w_on;
    rx_clr   = fcr_off | (fcr_qual & w_rxclr);
    tx_clr   = fcr_off | (fcr_qual & w_txclr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      trig_q <= '0;
    end else begin
      if (fcr_wr)   fen_q  <= w_on;
      if (fcr_qual) trig_q <= w_trig;
    end
  end
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IER_W  = 4,
  parameter int unsigned TRIG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dlab,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_pop,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_push,
  input  logic              ev_rx_avail,
  input  logic              ev_rx_timeout,
  input  logic              ev_thr_empty,
  input  logic              ev_line_err,
  input  logic              ev_modem_chg,
  input  logic [DATA_W-3:0] iir_src,
  output logic              irq,
  output logic              fifo_en,
  output logic [TRIG_W-1:0] fifo_trig,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr
);
  timeunit 1ns; timeprecision 1ps;
  import uart_host_pkg::*;

  localparam int unsigned PAD_W = DATA_W - IER_W;

  logic buf_rd, buf_wr, ier_rd, ier_wr, iir_rd, fcr_wr;
  logic [IER_W-1:0] ier_q;
  logic irq_next, fcr_qual;
  logic [EV_N-1:0] ev_vec;

  assign ev_vec = {ev_modem_chg, ev_line_err, ev_thr_empty, ev_rx_timeout, ev_rx_avail};

  uhr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .dlab(dlab), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .ier_rd(ier_rd), .ier_wr(ier_wr),
    .iir_rd(iir_rd), .fcr_wr(fcr_wr)
  );

  uhr_ier #(.IER_W(IER_W), .EV_W(EV_N)) u_ier (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .wbits(bus_wdata[IER_W-1:0]),
    .ev(ev_vec), .fen(fifo_en), .ier_q(ier_q), .irq_q(irq), .irq_next(irq_next)
  );

  uhr_fcr #(.TRIG_W(TRIG_W)) u_fcr (
    .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr),
    .w_on(bus_wdata[FCR_ON]), .w_rxclr(bus_wdata[FCR_RXCLR]),
    .w_txclr(bus_wdata[FCR_TXCLR]), .w_trig(bus_wdata[FCR_TRIG +: TRIG_W]),
    .fen_q(fifo_en), .trig_q(fifo_trig), .rx_clr(rx_fifo_clr),
    .tx_clr(tx_fifo_clr), .fcr_qual(fcr_qual)
  );

  assign rx_pop  = buf_rd;
  assign tx_push = buf_wr;
  assign tx_data = bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (buf_rd)      bus_rdata = rx_data;
    else if (ier_rd) bus_rdata = {{PAD_W{1'b0}}, ier_q};
    else if (iir_rd) bus_rdata = iir_view(fifo_en, |ier_q, iir_src);
  end
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dlab,
  input logic [2:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       rx_pop,
  input logic       tx_push,
  input logic [3:0] ier_q,
  input logic       irq,
  input logic       fifo_en,
  input logic [1:0] fifo_trig,
  input logic       rx_fifo_clr,
  input logic       tx_fifo_clr
);
  timeunit 1ns; timeprecision 1ps;

  a_r2_no_strobe_dlab: assert property (@(posedge clk) disable iff (!rst_n)
    dlab |-> (!rx_pop && !tx_push));

  a_r4_ier_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !dlab && bus_addr == 3'd1) |-> (bus_rdata[7:4] == 4'd0));

  a_r6_masked_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == 4'd0) |=> !irq);

  a_r8_off_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |-> (rx_fifo_clr && tx_fifo_clr));

  a_r8_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |=> !fifo_en);

  a_r9_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |=> $stable(fifo_trig));

  a_r9_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && bus_wdata[0]) |=> fifo_en);
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dlab(dlab), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_pop(rx_pop),
  .tx_push(tx_push), .ier_q(ier_q), .irq(irq), .fifo_en(fifo_en),
  .fifo_trig(fifo_trig), .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr)
);

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dlab = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, rx_data = 8'h00, tx_data;
  logic       rx_pop, tx_push, irq, fifo_en, rx_fifo_clr, tx_fifo_clr;
  logic [1:0] fifo_trig;
  logic [4:0] ev = '0;
  logic [5:0] iir_src = 6'h00;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [3:0] m_ier = '0;
  logic       m_fen = 1'b0;
  logic [1:0] m_trig = '0;

  always #2.5 clk = ~clk;

  uart_host_regs u_uart_host_regs (
    .clk(clk), .rst_n(rst_n), .dlab(dlab), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_data(rx_data),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push),
    .ev_rx_avail(ev[0]), .ev_rx_timeout(ev[1]), .ev_thr_empty(ev[2]),
    .ev_line_err(ev[3]), .ev_modem_chg(ev[4]), .iir_src(iir_src), .irq(irq),
    .fifo_en(fifo_en), .fifo_trig(fifo_trig), .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a, input logic dl);
    logic [7:0] v;
    v = 8'h00;
    if (a == 3'd0 && !dl) v = rx_data;
    else if (a == 3'd1 && !dl) v = 8'h00 + m_ier;
    else if (a == 3'd2) begin
      v = (m_ier != 0) ? {2'b00, iir_src} : 8'h01;
      if (m_fen) v = v + 8'hC0;
    end
    return v;
  endfunction

  function automatic logic exp_irq(input logic [4:0] e);
    int hits;
    hits = 0;
    if (m_ier[0] && e[0]) hits++;
    if (m_ier[0] && e[1] && m_fen) hits++;
    if (m_ier[1] && e[2]) hits++;
    if (m_ier[2] && e[3]) hits++;
    if (m_ier[3] && e[4]) hits++;
    return hits > 0;
  endfunction

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d, input logic dl);
    logic exp_rx, exp_tx;
    @(negedge clk);
    dlab = dl; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    chk("R2 tx_push", tx_push, (a == 3'd0 && !dl));
    chk("R2 rx_pop on write", rx_pop, 1'b0);
    if (a == 3'd0 && !dl) chk("R2 tx_data", tx_data, d);
    exp_rx = (a == 3'd2) && (!d[0] || d[1]);
    exp_tx = (a == 3'd2) && (!d[0] || d[2]);
    chk("R8/R9/R10 rx_fifo_clr", rx_fifo_clr, exp_rx);
    chk("R8/R9/R10 tx_fifo_clr", tx_fifo_clr, exp_tx);
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'd1 && !dl) m_ier = d[3:0];
    if (a == 3'd2) begin
      m_fen = d[0];
      if (d[0]) m_trig = d[7:6];
    end
    chk("R8/R9 fifo_en", fifo_en, m_fen);
    chk("R9/R10 fifo_trig", fifo_trig, m_trig);
  endtask

  task automatic do_rd(input logic [2:0] a, input logic dl);
    @(negedge clk);
    dlab = dl; bus_addr = a; bus_rd = 1'b1;
    #1;
    chk("R2/R3/R4/R6/R7 rdata", bus_rdata, exp_read(a, dl));
    chk("R2 rx_pop", rx_pop, (a == 3'd0 && !dl));
    chk("R2 tx_push on read", tx_push, 1'b0);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'hA5; vals[2] = 8'h5A; vals[3] = 8'hFF; vals[4] = 8'h3C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 fifo_en", fifo_en, 1'b0);
    chk("R1 fifo_trig", fifo_trig, 2'b00);
    do_rd(3'd1, 1'b0);
    do_rd(3'd2, 1'b0);

    // Decode sweep: every offset, both dlab values, several data patterns
    for (int dl = 0; dl < 2; dl++)
      for (int a = 0; a < 8; a++)
        for (int k = 0; k < 5; k++) begin
          rx_data = vals[k] ^ 8'(a * 17);
          iir_src = 6'(vals[k] + 8'(a));
          do_wr(3'(a), vals[k] ^ 8'(dl), dl[0]);
          do_rd(3'(a), dl[0]);
          do_rd(3'(a), ~dl[0]);
          do_rd(3'd1, 1'b0);
          do_rd(3'd2, 1'b1);
        end

    // R4 all IER values
    for (int d = 0; d < 256; d += 7) begin
      do_wr(3'd1, 8'(d), 1'b0);
      do_rd(3'd1, 1'b0);
    end

    // R8/R9/R10 every FCR value from both mode states
    for (int st = 0; st < 2; st++)
      for (int d = 0; d < 256; d++) begin
        do_wr(3'd2, (st != 0) ? 8'h81 : 8'h00, 1'b0);
        do_wr(3'd2, 8'(d), d[3]);
      end

    // R5/R6 interrupt gating sweep
    for (int f = 0; f < 2; f++)
      for (int en = 0; en < 16; en++) begin
        do_wr(3'd2, 8'(f), 1'b0);
        do_wr(3'd1, 8'(en), 1'b0);
        for (int e = 0; e < 32; e++) begin
          @(negedge clk);
          ev = 5'(e);
          @(negedge clk);
          chk("R5/R6 irq", irq, exp_irq(5'(e)));
        end
        ev = '0;
      end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule